// File: doc/BRIEF.md
# Interrupt Acceptance and Masking Unit

This unit sits at the instruction-retire boundary of a small processor core and decides, once per retired instruction, whether an event is taken and which one. It owns two architectural flags: the interrupt-enable flag, which gates maskable external interrupts, and the resume flag, which suppresses instruction-breakpoint debug exceptions for one instruction. It also checks privilege on the instructions that set or clear the enable flag, and it holds off some event classes at the boundary right after a stack-segment load.

Each retire strobe carries a short code for the retiring instruction class, the current and I/O privilege levels, a flags-restore value, and the candidate events: a fault from the rest of the core, an instruction-breakpoint match, a single-step trap and an external interrupt request with its vector and source. The gate type that the handler will be entered through is also supplied. One clock after a retire strobe the unit reports the chosen vector, whether an error code is pushed, and whether a privilege fault was raised. Held-off events are not stored: their sources keep them raised and the next retire boundary evaluates them again.

Top module: `irq_accept_unit`

## Requirements
- R1: Reset clears the enable flag, the resume flag and all decision outputs; outside a retire strobe (`retire_i` = 0) neither flag changes and `take_o` is 0 one cycle later.
- R2: An external request is taken only when the enable flag is 1 at the retire strobe; the decision appears on `take_o`/`take_vec_o` on the clock edge that ends the strobe cycle.
- R3: With `ext_src_i` = 0 (pin) vectors 0 to 32 are acceptable; with `ext_src_i` = 1 (local controller) only 16 to 32 are; a vector outside its source's range is not taken.
- R4: A taken external interrupt never pushes an error code, also when its vector lies in the exception range 0 to 31.
- R5: Op codes 1 (set enable) and 2 (clear enable) write the flag when `cpl_i` <= `iopl_i`; otherwise `gp_fault_o` pulses, vector 13 is taken with an error code, and the instruction does not change the flag.
- R6: Taking any event with `gate_trap_i` = 0 (interrupt gate) clears the enable flag; with `gate_trap_i` = 1 (trap gate) the entry leaves it as the instruction set it.
- R7: Op code 5 (flags restore) loads the enable flag from `flags_ie_i` and the resume flag from `flags_rf_i`.
- R8: A breakpoint match raises debug vector 1 without error code while the resume flag is 0 and is ignored while it is 1.
- R9: The resume flag returns to 0 after any retire that takes no fault, except op code 5, which loads it; a retire that takes a fault keeps it.
- R10: At the retire of op code 3 (stack segment loaded by move or pop) external interrupts, breakpoint matches and single-step traps are not taken while faults still are; op code 4 (combined segment-and-pointer load) blocks nothing, and the following boundary is open again.
- R11: Priority at one boundary: an incoming fault (`fault_i`, with its own vector and error-code bit), then the privilege fault, then debug (breakpoint or single-step), then the external interrupt.
- R12: When a fault is taken the retiring instruction's own flag update (op codes 1, 2, 5) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One-cycle strobe: an instruction boundary is evaluated |
| op_i | input | 3 | Retiring instruction class: 0 plain, 1 set enable, 2 clear enable, 3 stack-segment move/pop, 4 combined stack load, 5 flags restore |
| cpl_i | input | PL_W | Current privilege level |
| iopl_i | input | PL_W | I/O privilege level |
| flags_ie_i | input | 1 | Enable-flag value for a flags restore |
| flags_rf_i | input | 1 | Resume-flag value for a flags restore |
| fault_i | input | 1 | A fault is reported for the retiring instruction |
| fault_vec_i | input | VEC_W | Vector of that fault |
| fault_err_i | input | 1 | That fault pushes an error code |
| bp_match_i | input | 1 | Instruction-breakpoint match |
| step_i | input | 1 | Single-step trap pending |
| ext_req_i | input | 1 | Maskable external interrupt request |
| ext_src_i | input | 1 | Request source: 0 pin, 1 local controller |
| ext_vec_i | input | VEC_W | Requested vector |
| gate_trap_i | input | 1 | Handler gate type: 1 trap gate, 0 interrupt gate |
| take_o | output | 1 | An event was taken at the last boundary |
| take_vec_o | output | VEC_W | Vector of the taken event |
| take_err_o | output | 1 | An error code is pushed for it |
| gp_fault_o | output | 1 | Privilege fault raised by a set/clear-enable instruction |
| ie_o | output | 1 | Interrupt-enable flag |
| rf_o | output | 1 | Resume flag |

## Verification
On every cycle the assertions guard the flag rules that are local in time: an interrupt-gate entry clears the enable flag, a refused set/clear leaves it alone, the resume flag drops after a clean retire, an external interrupt is never taken with the flag low or with an error code, and only faults escape the stack-segment shadow. What the assertions cannot see is the ordering across several boundaries: that a held-off request is taken at the next open boundary, that vector ranges differ between the two sources, that a restore followed by a breakpoint is suppressed exactly once, and the full priority ranking; the bench's instruction sequences show these against an independent flag model.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int VEC_W = 8;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PLAIN      = 3'd0,
        OP_SET_IE     = 3'd1,
        OP_CLR_IE     = 3'd2,
        OP_SS_LOAD    = 3'd3,
        OP_SS_PAIR    = 3'd4,
        OP_FLAGS_LOAD = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_FAULT = 2'd1,
        CLS_DEBUG = 2'd2,
        CLS_EXT   = 2'd3
    } cls_e;

    typedef struct packed {
        logic             take;
        cls_e             cls;
        logic [VEC_W-1:0] vec;
        logic             err;
        logic             gp;
    } decision_t;

    typedef struct packed {
        logic ie;
        logic rf;
    } flags_t;

endpackage

// File: rtl/irq_priv_check.sv
module irq_priv_check
    import irq_accept_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [PL_W-1:0] cpl_i,
    input  logic [PL_W-1:0] iopl_i,
    output logic            gp_o,
    output logic            wr_en_o,
    output logic            wr_val_o
);

    logic is_flag_op;
    logic allowed;

    always_comb begin
        is_flag_op = (op_e'(op_i) == OP_SET_IE) || (op_e'(op_i) == OP_CLR_IE);
        allowed    = (cpl_i <= iopl_i);
        gp_o       = is_flag_op && !allowed;
        wr_en_o    = is_flag_op && allowed;
        wr_val_o   = (op_e'(op_i) == OP_SET_IE);
    end

endmodule

// File: rtl/irq_event_pick.sv
module irq_event_pick
    import irq_accept_pkg::*;
#(
    parameter int GP_VEC        = 13,
    parameter int DBG_VEC       = 1,
    parameter int PIN_MAX_VEC   = 32,
    parameter int LOCAL_MIN_VEC = 16,
    parameter int LOCAL_MAX_VEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic             ie_i,
    input  logic             rf_i,
    input  logic             gp_i,
    input  logic             fault_i,
    input  logic [VEC_W-1:0] fault_vec_i,
    input  logic             fault_err_i,
    input  logic             bp_match_i,
    input  logic             step_i,
    input  logic             ext_req_i,
    input  logic             ext_src_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    output decision_t        dec_o
);

    localparam logic [VEC_W-1:0] GP_V      = VEC_W'(GP_VEC);
    localparam logic [VEC_W-1:0] DBG_V     = VEC_W'(DBG_VEC);
    localparam logic [VEC_W-1:0] PIN_HI    = VEC_W'(PIN_MAX_VEC);
    localparam logic [VEC_W-1:0] LOCAL_LO  = VEC_W'(LOCAL_MIN_VEC);
    localparam logic [VEC_W-1:0] LOCAL_HI  = VEC_W'(LOCAL_MAX_VEC);

    logic shadow;
    logic vec_ok;
    logic dbg_ev;
    logic ext_ev;

    always_comb begin
        shadow = (op_e'(op_i) == OP_SS_LOAD);
        if (ext_src_i) begin
            vec_ok = (ext_vec_i >= LOCAL_LO) && (ext_vec_i <= LOCAL_HI);
        end else begin
            vec_ok = (ext_vec_i <= PIN_HI);
        end
        dbg_ev = !shadow && ((bp_match_i && !rf_i) || step_i);
        ext_ev = !shadow && ext_req_i && ie_i && vec_ok;

        dec_o    = '0;
        dec_o.gp = gp_i;
        if (fault_i) begin
            dec_o.take = 1'b1;
            dec_o.cls  = CLS_FAULT;
            dec_o.vec  = fault_vec_i;
            dec_o.err  = fault_err_i;
        end else if (gp_i) begin
            dec_o.take = 1'b1;
            dec_o.cls  = CLS_FAULT;
            dec_o.vec  = GP_V;
            dec_o.err  = 1'b1;
        end else if (dbg_ev) begin
            dec_o.take = 1'b1;
            dec_o.cls  = CLS_DEBUG;
            dec_o.vec  = DBG_V;
        end else if (ext_ev) begin
            dec_o.take = 1'b1;
            dec_o.cls  = CLS_EXT;
            dec_o.vec  = ext_vec_i;
        end
    end

    AST_SHADOW_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && shadow && dec_o.take) |-> (dec_o.cls == CLS_FAULT)); // R10

    AST_EXT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && dec_o.take && dec_o.cls == CLS_EXT) |-> ie_i); // R2

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import irq_accept_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            fault_i,
    input  logic            gp_i,
    input  logic            wr_en_i,
    input  logic            wr_val_i,
    input  logic            flags_ie_i,
    input  logic            flags_rf_i,
    input  logic            take_i,
    input  logic            gate_trap_i,
    output flags_t          flags_o
);

    flags_t flags_d, flags_q;
    logic   faulted;
    logic   is_load;

    always_comb begin
        flags_d = flags_q;
        faulted = fault_i || gp_i;
        is_load = (op_e'(op_i) == OP_FLAGS_LOAD);
        if (retire_i) begin
            if (!faulted) begin
                if (wr_en_i) begin
                    flags_d.ie = wr_val_i;
                end
                if (is_load) begin
                    flags_d.ie = flags_ie_i;
                    flags_d.rf = flags_rf_i;
                end else begin
                    flags_d.rf = 1'b0;
                end
            end
            if (take_i && !gate_trap_i) begin
                flags_d.ie = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i |=> ($stable(flags_q.ie) && $stable(flags_q.rf))); // R1

    AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && take_i && !gate_trap_i) |=> !flags_q.ie); // R6

    AST_GP_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && gp_i && gate_trap_i) |=> $stable(flags_q.ie)); // R5

    AST_RF_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !fault_i && !gp_i && op_e'(op_i) != OP_FLAGS_LOAD) |=> !flags_q.rf); // R9

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int PL_W          = 2,
    parameter int GP_VEC        = 13,
    parameter int DBG_VEC       = 1,
    parameter int PIN_MAX_VEC   = 32,
    parameter int LOCAL_MIN_VEC = 16,
    parameter int LOCAL_MAX_VEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [PL_W-1:0]  cpl_i,
    input  logic [PL_W-1:0]  iopl_i,
    input  logic             flags_ie_i,
    input  logic             flags_rf_i,
    input  logic             fault_i,
    input  logic [VEC_W-1:0] fault_vec_i,
    input  logic             fault_err_i,
    input  logic             bp_match_i,
    input  logic             step_i,
    input  logic             ext_req_i,
    input  logic             ext_src_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    input  logic             gate_trap_i,
    output logic             take_o,
    output logic [VEC_W-1:0] take_vec_o,
    output logic             take_err_o,
    output logic             gp_fault_o,
    output logic             ie_o,
    output logic             rf_o
);

    logic      gp;
    logic      wr_en;
    logic      wr_val;
    flags_t    flags;
    decision_t dec;
    decision_t dec_d, dec_q;

    irq_priv_check #(.PL_W(PL_W)) i_priv (
        .op_i     (op_i),
        .cpl_i    (cpl_i),
        .iopl_i   (iopl_i),
        .gp_o     (gp),
        .wr_en_o  (wr_en),
        .wr_val_o (wr_val)
    );

    irq_event_pick #(
        .GP_VEC        (GP_VEC),
        .DBG_VEC       (DBG_VEC),
        .PIN_MAX_VEC   (PIN_MAX_VEC),
        .LOCAL_MIN_VEC (LOCAL_MIN_VEC),
        .LOCAL_MAX_VEC (LOCAL_MAX_VEC)
    ) i_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire_i),
        .op_i        (op_i),
        .ie_i        (flags.ie),
        .rf_i        (flags.rf),
        .gp_i        (gp),
        .fault_i     (fault_i),
        .fault_vec_i (fault_vec_i),
        .fault_err_i (fault_err_i),
        .bp_match_i  (bp_match_i),
        .step_i      (step_i),
        .ext_req_i   (ext_req_i),
        .ext_src_i   (ext_src_i),
        .ext_vec_i   (ext_vec_i),
        .dec_o       (dec)
    );

    irq_flag_regs i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire_i),
        .op_i        (op_i),
        .fault_i     (fault_i),
        .gp_i        (gp),
        .wr_en_i     (wr_en),
        .wr_val_i    (wr_val),
        .flags_ie_i  (flags_ie_i),
        .flags_rf_i  (flags_rf_i),
        .take_i      (dec.take),
        .gate_trap_i (gate_trap_i),
        .flags_o     (flags)
    );

    always_comb begin
        dec_d = '0;
        if (retire_i) begin
            dec_d = dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign take_o     = dec_q.take;
    assign take_vec_o = dec_q.vec;
    assign take_err_o = dec_q.err;
    assign gp_fault_o = dec_q.gp;
    assign ie_o       = flags.ie;
    assign rf_o       = flags.rf;

    AST_TAKE_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(retire_i)); // R2

    AST_EXT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.take && dec_q.cls == CLS_EXT) |-> !dec_q.err); // R4

    AST_GP_IS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> (take_o && dec_q.cls == CLS_FAULT)); // R5

endmodule

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retire_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [1:0] cpl_i = 2'd0;
    logic [1:0] iopl_i = 2'd0;
    logic       flags_ie_i = 1'b0;
    logic       flags_rf_i = 1'b0;
    logic       fault_i = 1'b0;
    logic [7:0] fault_vec_i = 8'd0;
    logic       fault_err_i = 1'b0;
    logic       bp_match_i = 1'b0;
    logic       step_i = 1'b0;
    logic       ext_req_i = 1'b0;
    logic       ext_src_i = 1'b0;
    logic [7:0] ext_vec_i = 8'd0;
    logic       gate_trap_i = 1'b1;
    logic       take_o;
    logic [7:0] take_vec_o;
    logic       take_err_o;
    logic       gp_fault_o;
    logic       ie_o;
    logic       rf_o;

    always #4 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .op_i(op_i),
        .cpl_i(cpl_i), .iopl_i(iopl_i), .flags_ie_i(flags_ie_i), .flags_rf_i(flags_rf_i),
        .fault_i(fault_i), .fault_vec_i(fault_vec_i), .fault_err_i(fault_err_i),
        .bp_match_i(bp_match_i), .step_i(step_i), .ext_req_i(ext_req_i),
        .ext_src_i(ext_src_i), .ext_vec_i(ext_vec_i), .gate_trap_i(gate_trap_i),
        .take_o(take_o), .take_vec_o(take_vec_o), .take_err_o(take_err_o),
        .gp_fault_o(gp_fault_o), .ie_o(ie_o), .rf_o(rf_o)
    );

    typedef struct {
        bit       take;
        bit [7:0] vec;
        bit       err;
        bit       gp;
        bit       ie;
        bit       rf;
        string    tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    m_ie = 1'b0;
    bit    m_rf = 1'b0;
    logic  seen = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: computes expected outcome from the requirements, then strobes
    task automatic retire(input string tag);
        exp_t e;
        bit   shadow, gp, faulted, vec_ok;
        shadow = (op_i == 3'd3);                                   // R10
        gp = ((op_i == 3'd1) || (op_i == 3'd2)) && (cpl_i > iopl_i); // R5
        vec_ok = ext_src_i ? (ext_vec_i >= 16 && ext_vec_i <= 32) : (ext_vec_i <= 32); // R3
        e = '{take: 0, vec: 0, err: 0, gp: gp, ie: m_ie, rf: m_rf, tag: tag};
        if (fault_i) begin                                         // R11
            e.take = 1; e.vec = fault_vec_i; e.err = fault_err_i;
        end else if (gp) begin
            e.take = 1; e.vec = 8'd13; e.err = 1;
        end else if (!shadow && ((bp_match_i && !m_rf) || step_i)) begin // R8
            e.take = 1; e.vec = 8'd1;
        end else if (!shadow && ext_req_i && m_ie && vec_ok) begin // R2 R4
            e.take = 1; e.vec = ext_vec_i;
        end
        faulted = fault_i || gp;
        if (!faulted) begin                                        // R12
            if (op_i == 3'd1) e.ie = 1;
            if (op_i == 3'd2) e.ie = 0;
            if (op_i == 3'd5) begin e.ie = flags_ie_i; e.rf = flags_rf_i; end // R7
            else e.rf = 0;                                          // R9
        end
        if (e.take && !gate_trap_i) e.ie = 0;                      // R6
        m_ie = e.ie;
        m_rf = e.rf;
        q.push_back(e);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
    endtask

    task automatic clear_inputs();
        op_i = 3'd0; fault_i = 0; fault_vec_i = 0; fault_err_i = 0; bp_match_i = 0;
        step_i = 0; ext_req_i = 0; ext_src_i = 0; ext_vec_i = 0; gate_trap_i = 1;
        cpl_i = 0; iopl_i = 0; flags_ie_i = 0; flags_rf_i = 0;
    endtask

    // monitor: compares each decision in the cycle after its strobe
    always @(posedge clk) seen <= rst_n && retire_i;

    always @(negedge clk) begin
        if (seen) begin
            if (q.size() == 0) begin
                chk("scoreboard", "unexpected decision", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "take", int'(take_o), int'(e.take));
                if (e.take) begin
                    chk(e.tag, "vec", int'(take_vec_o), int'(e.vec));
                    chk(e.tag, "err", int'(take_err_o), int'(e.err));
                end
                chk(e.tag, "gp", int'(gp_fault_o), int'(e.gp));
                chk(e.tag, "ie", int'(ie_o), int'(e.ie));
                chk(e.tag, "rf", int'(rf_o), int'(e.rf));
            end
        end else if (rst_n && !done) begin
            chk("R1", "idle take", int'(take_o), 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset ie", int'(ie_o), 0);
        chk("R1", "reset rf", int'(rf_o), 0);
        chk("R1", "reset take", int'(take_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: external request with enable flag clear is held off
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd40 - 8'd8; retire("R2 masked");
        // R5: permitted set
        clear_inputs(); op_i = 3'd1; retire("R5 set allowed");
        // R2 R4 R6: exception-range vector via pin, interrupt gate
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd14; gate_trap_i = 0; retire("R4 R6 pin vec14");
        chk("R6", "ie after int gate", int'(ie_o), 0);
        clear_inputs(); op_i = 3'd1; retire("R5 set again");
        // R3: local controller below 16 ignored, 20 accepted through trap gate
        clear_inputs(); ext_req_i = 1; ext_src_i = 1; ext_vec_i = 8'd10; retire("R3 local low");
        clear_inputs(); ext_req_i = 1; ext_src_i = 1; ext_vec_i = 8'd20; retire("R3 R6 local 20 trap");
        clear_inputs(); ext_req_i = 1; ext_src_i = 1; ext_vec_i = 8'd33; retire("R3 local high");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd33; retire("R3 pin 33");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd32; retire("R3 pin 32");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd0; retire("R3 R4 pin 0");
        // R5: refused clear raises privilege fault, flag kept
        clear_inputs(); op_i = 3'd2; cpl_i = 3; iopl_i = 0; retire("R5 clear refused");
        clear_inputs(); op_i = 3'd1; cpl_i = 3; iopl_i = 2; gate_trap_i = 0; retire("R5 R6 set refused int gate");
        clear_inputs(); op_i = 3'd1; cpl_i = 2; iopl_i = 3; retire("R5 set cpl<iopl");
        clear_inputs(); op_i = 3'd2; cpl_i = 2; iopl_i = 2; retire("R5 clear cpl=iopl");
        // R1: idle cycles hold flags
        repeat (3) @(negedge clk);
        chk("R1", "ie held idle", int'(ie_o), 0);
        // R7 R8 R9: restore with resume flag, breakpoint suppressed once
        clear_inputs(); op_i = 3'd5; flags_ie_i = 1; flags_rf_i = 1; retire("R7 restore");
        clear_inputs(); bp_match_i = 1; retire("R8 R9 bp suppressed");
        clear_inputs(); bp_match_i = 1; retire("R8 bp taken");
        // R9 R12: fault keeps resume flag and discards restore
        clear_inputs(); op_i = 3'd5; flags_ie_i = 1; flags_rf_i = 1; retire("R7 restore2");
        clear_inputs(); op_i = 3'd5; flags_ie_i = 0; flags_rf_i = 0; fault_i = 1;
        fault_vec_i = 8'd14; fault_err_i = 1; retire("R9 R12 faulting restore");
        clear_inputs(); bp_match_i = 1; retire("R9 bp after fault suppressed");
        clear_inputs(); op_i = 3'd2; fault_i = 1; fault_vec_i = 8'd6; retire("R12 faulting clear");
        // R10: stack-segment shadow
        clear_inputs(); op_i = 3'd3; ext_req_i = 1; ext_vec_i = 8'd40; retire("R10 shadow ext");
        clear_inputs(); op_i = 3'd3; step_i = 1; bp_match_i = 1; retire("R10 shadow debug");
        clear_inputs(); op_i = 3'd3; step_i = 1; fault_i = 1; fault_vec_i = 8'd12; fault_err_i = 1;
        retire("R10 shadow fault");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd25; retire("R10 after shadow");
        clear_inputs(); op_i = 3'd4; ext_req_i = 1; ext_vec_i = 8'd26; retire("R10 combined load");
        // R11: priority ordering
        clear_inputs(); fault_i = 1; fault_vec_i = 8'd8; fault_err_i = 1; step_i = 1; ext_req_i = 1;
        ext_vec_i = 8'd30; op_i = 3'd2; cpl_i = 3; retire("R11 fault first");
        clear_inputs(); op_i = 3'd2; cpl_i = 3; step_i = 1; ext_req_i = 1; ext_vec_i = 8'd30;
        retire("R11 gp over debug");
        clear_inputs(); step_i = 1; ext_req_i = 1; ext_vec_i = 8'd30; retire("R11 debug over ext");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd30; gate_trap_i = 0; retire("R11 R6 ext last");
        clear_inputs(); ext_req_i = 1; ext_vec_i = 8'd30; retire("R2 held after clear");
        clear_inputs();
        repeat (3) @(negedge clk);
        chk("scoreboard", "queue empty", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule